// File: doc/BRIEF.md
# Two-Phase Shared-Multiplier FIR Filter

This block is an eight-tap finite impulse response filter that uses four multipliers instead of eight. It runs on a fast clock at twice the sample rate. Each accepted input sample starts two internal phases. In the first phase, coefficients h0..h3 are multiplied with the four newest stored samples, and the sum of those four products is held in a register. In the second phase, coefficients h4..h7 are multiplied with the four oldest stored samples, and that sum is added to the held value to form the output.

Samples arrive on a strobe that is high for one fast cycle. The strobe may come at most once every second cycle. Coefficients are written one at a time through a small write port and are kept across reset. The output is the full-precision signed sum, so it can never overflow. A one-cycle valid pulse marks each new output.

Top module: `tdm_fir8`

## Requirements
- R1: Each output equals the sum over k = 0..7 of h[k]·x[n−k], as a 39-bit signed value, where x[n] is the newest accepted sample and x[n−k] are the older ones. Samples and coefficients are signed two's complement 18-bit values.
- R2: `y_valid` is high for exactly one cycle, three clock edges after the edge at which `sample_en` was accepted.
- R3: Phase 0 pairs h0..h3 with x[n]..x[n−3]. Phase 1 pairs h4..h7 with x[n−4]..x[n−7]. As a result, feeding a single 1 followed by zeros reproduces h0, h1, …, h7 in that order.
- R4: The delay line shifts only when a sample is accepted. While `sample_en` is low, no output is produced and the stored history stays as it is.
- R5: A `sample_en` pulse in the cycle right after an accepted sample (the phase-0 cycle) is ignored. It produces no output and does not enter the delay line.
- R6: `y_out` holds its value between valid pulses.
- R7: A write with `coef_we` high stores `coef_data` as coefficient h[`coef_addr`] (address 0..7 selects h0..h7). The write is used by every sample accepted after it.
- R8: Synchronous active-high `rst` clears the delay line, the phase state, the held partial sum, `y_out` and `y_valid`. The coefficients are kept.
- R9: The extreme case, where all eight products are (−2^17)·(−2^17), gives +2^37 with no wrap-around.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast clock, twice the sample rate |
| rst | input | 1 | Synchronous reset, active high |
| sample_en | input | 1 | New-sample strobe |
| sample_in | input | 18 | Signed input sample |
| coef_we | input | 1 | Coefficient write enable |
| coef_addr | input | 3 | Coefficient index 0..7 |
| coef_data | input | 18 | Signed coefficient value |
| y_out | output | 39 | Signed filter output |
| y_valid | output | 1 | Output strobe, one cycle |

## Verification
Each fault shows at the ports within one sample, and how it shows depends on where it is.
- A wrong phase-to-coefficient pairing swaps taps. The impulse response then comes out in the wrong order within four outputs.
- A partial-sum register that loads at the wrong time or fails to clear corrupts the very next output.
- A delay line that shifts on an ignored strobe shifts every later result against the direct-form reference.
- A wrong phase sequence moves the valid pulse away from its third-edge slot at once.

// File: rtl/tdm_fir8.sv
module tdm_fir8 #(
  parameter int DW   = 18,
  parameter int CW   = 18,
  parameter int TAPS = 8
) (
  input  logic                                   clk,
  input  logic                                   rst,
  input  logic                                   sample_en,
  input  logic signed [DW-1:0]                   sample_in,
  input  logic                                   coef_we,
  input  logic [$clog2(TAPS)-1:0]                coef_addr,
  input  logic signed [CW-1:0]                   coef_data,
  output logic signed [DW+CW+$clog2(TAPS)-1:0]   y_out,
  output logic                                   y_valid
);
  localparam int LANES = TAPS / 2;
  localparam int PW    = DW + CW;
  localparam int LW    = PW + $clog2(LANES);
  localparam int OW    = PW + $clog2(TAPS);

  logic signed [DW-1:0] taps [TAPS];
  logic signed [CW-1:0] coef [TAPS];
  logic signed [PW-1:0] prod [LANES];
  logic signed [LW-1:0] lane_sum, partial;
  logic ph0, ph1;

  wire accept = sample_en & ~ph0;

  always_ff @(posedge clk) begin
    if (rst) begin
      ph0 <= 1'b0;
      ph1 <= 1'b0;
    end else begin
      ph0 <= accept;
      ph1 <= ph0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < TAPS; i++) taps[i] <= '0;
    end else if (accept) begin
      taps[0] <= sample_in;
      for (int i = 1; i < TAPS; i++) taps[i] <= taps[i-1];
    end
  end

  always_ff @(posedge clk) begin
    if (coef_we) coef[coef_addr] <= coef_data;
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    wire signed [CW-1:0] c_sel = ph1 ? coef[g+LANES] : coef[g];
    wire signed [DW-1:0] x_sel = ph1 ? taps[g+LANES] : taps[g];
    assign prod[g] = c_sel * x_sel;
  end

  always_comb begin
    lane_sum = '0;
    for (int i = 0; i < LANES; i++) lane_sum = lane_sum + LW'(prod[i]);
  end

  always_ff @(posedge clk) begin
    if (rst) partial <= '0;
    else if (ph0) partial <= lane_sum;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      y_out   <= '0;
      y_valid <= 1'b0;
    end else begin
      y_valid <= ph1;
      if (ph1) y_out <= OW'(partial) + OW'(lane_sum);
    end
  end

  // R3
  phase_order_chk: assert property (@(posedge clk) disable iff (rst) ph0 |=> ph1);
  // R2
  valid_follow_chk: assert property (@(posedge clk) disable iff (rst) ph1 |=> y_valid);
  // R2
  valid_pulse_chk: assert property (@(posedge clk) disable iff (rst) y_valid |=> !y_valid);
  // R4
  hist_hold_chk: assert property (@(posedge clk) disable iff (rst) !sample_en |=> $stable(taps[0]));
  // R6
  out_hold_chk: assert property (@(posedge clk) disable iff (rst) !ph1 |=> $stable(y_out));
  // R8
  reset_clear_chk: assert property (@(posedge clk) rst |=> (!y_valid && !ph0 && !ph1 && y_out == '0));
endmodule

// File: tb/tdm_fir8_test.sv
module tdm_fir8_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sample_en = 1'b0;
  logic signed [17:0] sample_in = '0;
  logic coef_we = 1'b0;
  logic [2:0] coef_addr = '0;
  logic signed [17:0] coef_data = '0;
  logic signed [38:0] y_out;
  logic y_valid;

  tdm_fir8 uut (.clk, .rst, .sample_en, .sample_in, .coef_we, .coef_addr,
                .coef_data, .y_out, .y_valid);

  always #2 clk = ~clk;

  int checks = 0, fails = 0, cyc = 0;
  bit done = 0;
  longint ref_x [8];
  longint ref_h [8];
  longint exp_q [$];
  int     cyc_q [$];
  longint last_y = 0;

  localparam logic signed [17:0] VEC [16] = '{
    18'sd5, -18'sd3, 18'sd100, 18'sd131071, -18'sd131072, 18'sd0, 18'sd77, -18'sd1,
    18'sd12345, -18'sd54321, 18'sd2, 18'sd2, 18'sd9999, -18'sd7, 18'sd65536, 18'sd1};

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      if (y_valid) begin
        if (exp_q.size() == 0) check(0, "R5 unexpected output", longint'(y_out), 0);
        else begin
          longint e; int c;
          e = exp_q.pop_front();
          c = cyc_q.pop_front();
          check(longint'(y_out) == e, "R1 output value", longint'(y_out), e);
          check(cyc == c, "R2 latency", cyc, c);
        end
        last_y = longint'(y_out);
      end else if (longint'(y_out) != last_y) begin
        check(0, "R6 output hold", longint'(y_out), last_y);
      end
    end
  end

  task automatic model_push(input longint s);
    longint acc = 0;
    for (int i = 7; i > 0; i--) ref_x[i] = ref_x[i-1];
    ref_x[0] = s;
    for (int i = 0; i < 8; i++) acc += ref_h[i] * ref_x[i];
    exp_q.push_back(acc);
    cyc_q.push_back(cyc + 3);
  endtask

  task automatic load_coef(input int idx, input logic signed [17:0] v);
    @(negedge clk);
    coef_we = 1; coef_addr = 3'(idx); coef_data = v;
    ref_h[idx] = longint'(v);
    @(negedge clk);
    coef_we = 0;
  endtask

  task automatic push(input logic signed [17:0] s);
    @(negedge clk);
    sample_en = 1; sample_in = s;
    model_push(longint'(s));
    @(negedge clk);
    sample_en = 0;
  endtask

  task automatic drain;
    repeat (6) @(negedge clk);
    check(exp_q.size() == 0, "R2 all outputs seen", exp_q.size(), 0);
  endtask

  task automatic do_reset;
    @(negedge clk);
    rst = 1;
    @(negedge clk);
    @(negedge clk);
    check(y_valid == 0, "R8 reset valid", y_valid, 0);
    check(y_out == 0, "R8 reset output", longint'(y_out), 0);
    rst = 0;
    last_y = 0;
    for (int i = 0; i < 8; i++) ref_x[i] = 0;
  endtask

  initial begin
    for (int i = 0; i < 8; i++) begin ref_x[i] = 0; ref_h[i] = 0; end
    repeat (3) @(negedge clk);
    check(y_valid == 0, "R8 reset valid", y_valid, 0);
    check(y_out == 0, "R8 reset output", longint'(y_out), 0);
    rst = 0;

    // R7 distinct coefficients, R3 impulse response order
    for (int i = 0; i < 8; i++) load_coef(i, 18'(i * 11 + 3));
    push(18'sd1);
    for (int i = 0; i < 7; i++) push(18'sd0);
    drain();
    check(ref_h[0] == 3 && ref_h[7] == 80, "R3 impulse coef set", ref_h[7], 80);

    // R1 vector table, back-to-back every second cycle
    load_coef(2, -18'sd1000);
    load_coef(6, 18'sd131071);
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      sample_en = 1; sample_in = VEC[i];
      model_push(longint'(VEC[i]));
      @(negedge clk);
      sample_en = 0;
    end
    drain();

    // R5 strobe in phase-0 cycle ignored
    push(18'sd40);
    @(negedge clk);
    sample_en = 1; sample_in = 18'sd40;
    model_push(longint'(18'sd40));
    @(negedge clk);
    sample_in = -18'sd999;
    @(negedge clk);
    sample_en = 0;
    push(18'sd3);
    drain();

    // R4 idle gap: no outputs, history kept
    repeat (20) @(negedge clk);
    check(y_valid == 0, "R4 idle no output", y_valid, 0);
    push(18'sd0);
    drain();

    // R8 reset clears history, keeps coefficients
    do_reset();
    push(18'sd1);
    drain();
    check(last_y == ref_h[0], "R8 coefficients kept", last_y, ref_h[0]);

    // R9 extreme magnitude
    for (int i = 0; i < 8; i++) load_coef(i, -18'sd131072);
    for (int i = 0; i < 8; i++) push(-18'sd131072);
    drain();
    check(last_y == 64'sd137438953472, "R9 extreme sum", last_y, 64'sd137438953472);

    // R9 mixed extremes, negative result
    for (int i = 0; i < 8; i++) load_coef(i, 18'sd131071);
    push(-18'sd131072);
    drain();

    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule